// File: doc/BRIEF.md
# Sticky Edge-Triggered Interrupt Collector

This block watches a vector of internal status lines and raises a sticky flag for each line whose level changes while that line is unmasked. Rising and falling transitions both count. A level that is already present when a mask bit is opened, or when the flags are wiped, raises nothing. Only a later change does. The flags form a readable monitor vector. Their OR is the interrupt condition, which leaves the block on one pin through a selectable drive scheme.

Software clears flags in two ways: a one-cycle write strobe carrying a per-bit clear pattern, or a one-cycle clear-all strobe. Neither is stored, so both read back as zero. A board-level clear-all line, such as a general-purpose pin routed to this function, does the same as the clear-all strobe once it has passed a synchronizer. The pin is modelled as a data value plus an output enable. Together these give open-drain or push-pull drive of either polarity.

Top module: `irq_sticky_ctrl`

## Requirements
- R1: While reset is low and on the first cycle after it, every monitor bit reads 0 and the drive mode is 11. The pin is therefore driven (enable 1) at logic 1.
- R2: When a status bit differs from its value on the previous clock and its mask bit is 1, the matching monitor bit reads 1 after the next rising edge. This holds for both directions. The first cycle after reset produces no event.
- R3: A status change while the mask bit is 0 sets nothing. Opening the mask later over a level that no longer changes also sets nothing.
- R4: A set monitor bit stays set after its status line returns to its old level and after its mask bit goes to 0.
- R5: A cycle with the clear strobe high clears every monitor bit whose clear-pattern bit is 1. All other bits are left as they were. A pattern bit has no effect in a cycle where the strobe is low.
- R6: A cycle with the clear-all strobe high clears every monitor bit on the next edge.
- R7: The hardware clear-all input passes through a two-stage synchronizer. A level that is high before edge k clears every monitor bit at edge k+2, and at each following edge while it stays high.
- R8: When a set event and any clear (per-bit, clear-all or hardware) hit the same bit in the same cycle, the bit ends up set.
- R9: The interrupt is asserted exactly when at least one monitor bit is 1.
- R10: Pin drive for mode m and asserted level a, given as {enable, data}: 00 gives {a,0}; 01 gives {a,1}; 10 gives {1,a}; 11 gives {1,~a}.
- R11: A mode write strobe loads the 2-bit mode at the next edge. Without the strobe the mode input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| status_i | input | 16 | Internal status lines to watch |
| mask_i | input | 16 | Per-bit enable for flag setting |
| clr_we_i | input | 1 | One-cycle strobe applying clr_bits_i |
| clr_bits_i | input | 16 | Per-bit clear pattern |
| clr_all_i | input | 1 | One-cycle strobe clearing all flags |
| hw_clr_pin_i | input | 1 | Asynchronous hardware clear-all line |
| mode_we_i | input | 1 | One-cycle strobe loading mode_i |
| mode_i | input | 2 | New pin drive mode |
| monitor_o | output | 16 | Sticky flag vector |
| irq_pin_o | output | 1 | Pin data value |
| irq_pin_oe_o | output | 1 | Pin output enable |

## Verification
A status transition and a clear aimed at the same flag can fall in the same cycle. The bench provokes this by toggling a status line in the same cycle as a per-bit clear, a clear-all strobe and a synchronized hardware clear for that bit. The flag must survive each time while the other flags are wiped. A bench-side model built from the requirements is compared with the monitor vector and both pin outputs after every cycle. This covers a per-bit sweep in both directions and mask states, all four drive modes, and a long pseudo-random run in which such collisions arise naturally.

// File: rtl/irq_pkg.sv
// Package: shared types for the sticky interrupt collector.
// Assumes: nothing beyond IEEE 1800-2017.
package irq_pkg;

    // Pin drive schemes; the encoding is the register value software writes.
    typedef enum logic [1:0] {
        PIN_OD_ACT_LOW  = 2'b00,
        PIN_OD_ACT_HIGH = 2'b01,
        PIN_PP_ACT_HIGH = 2'b10,
        PIN_PP_ACT_LOW  = 2'b11
    } pin_mode_e;

    localparam pin_mode_e PIN_MODE_RESET = PIN_PP_ACT_LOW;

endpackage

// File: rtl/irq_sync.sv
// Module: irq_sync
// Brings one asynchronous level into the clock domain through a flop chain.
// Assumes: STAGES >= 2; output is low during and right after reset.
module irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the sampled level one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_change_det.sv
// Module: irq_change_det
// Flags every bit of a status vector that differs from its value one clock earlier.
// Assumes: the first cycle after reset has no valid history, so it reports nothing.
module irq_change_det #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] status_i,
    output logic [WIDTH-1:0] change_o
);
    logic [WIDTH-1:0] prev_q;
    logic             primed_q;

    // Remember the last sampled status and whether that sample is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= status_i;
            primed_q <= 1'b1;
        end
    end

    // Report transitions in either direction once history exists.
    always_comb begin
        change_o = primed_q ? (status_i ^ prev_q) : '0;
    end

    // Stable status must never report a change on the following cycle. R2
    AST_STABLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(status_i) |-> (change_o == '0));  // R2
endmodule

// File: rtl/irq_flag_bank.sv
// Module: irq_flag_bank
// Holds the sticky flags; set requests override clear requests on the same bit.
// Assumes: set and clear vectors are already qualified by the caller.
module irq_flag_bank #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] flags_o
);
    logic [WIDTH-1:0] flags_q;
    logic [WIDTH-1:0] flags_d;

    // Next flags: drop cleared bits, then add set bits so a set is never lost.
    always_comb begin
        flags_d = (flags_q & ~clr_i) | set_i;
    end

    // Register the flag vector.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & $past(set_i)) == $past(set_i)));  // R8
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & $past(clr_i & ~set_i)) == '0));  // R5
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & $past(flags_q & ~clr_i)) == $past(flags_q & ~clr_i)));  // R4
endmodule

// File: rtl/irq_pin_drive.sv
// Module: irq_pin_drive
// Holds the pin drive mode and maps the interrupt level onto data and enable.
// Assumes: the mode resets to push-pull active-low.
module irq_pin_drive
    import irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_we_i,
    input  logic [1:0] mode_i,
    input  logic       irq_i,
    output logic       pin_o,
    output logic       pin_oe_o
);
    pin_mode_e mode_q;

    // Load a new drive mode on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         mode_q <= PIN_MODE_RESET;
        else if (mode_we_i) mode_q <= pin_mode_e'(mode_i);
    end

    // Translate the asserted level into pin data and enable for the mode.
    always_comb begin
        unique case (mode_q)
            PIN_OD_ACT_LOW:  begin pin_oe_o = irq_i; pin_o = 1'b0;   end
            PIN_OD_ACT_HIGH: begin pin_oe_o = irq_i; pin_o = 1'b1;   end
            PIN_PP_ACT_HIGH: begin pin_oe_o = 1'b1;  pin_o = irq_i;  end
            default:         begin pin_oe_o = 1'b1;  pin_o = ~irq_i; end
        endcase
    end

    AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_we_i |=> $stable(mode_q));  // R11
endmodule

// File: rtl/irq_sticky_ctrl.sv
// Module: irq_sticky_ctrl (top)
// Turns status transitions into sticky maskable flags and drives one interrupt pin.
// Assumes: clear and mode strobes last one cycle; hw_clr_pin_i is asynchronous.
module irq_sticky_ctrl #(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] status_i,
    input  logic [WIDTH-1:0] mask_i,
    input  logic             clr_we_i,
    input  logic [WIDTH-1:0] clr_bits_i,
    input  logic             clr_all_i,
    input  logic             hw_clr_pin_i,
    input  logic             mode_we_i,
    input  logic [1:0]       mode_i,
    output logic [WIDTH-1:0] monitor_o,
    output logic             irq_pin_o,
    output logic             irq_pin_oe_o
);
    logic [WIDTH-1:0] change_vec;
    logic [WIDTH-1:0] set_vec;
    logic [WIDTH-1:0] clr_vec;
    logic             hw_clr_sync;
    logic             irq_level;

    irq_sync #(.STAGES(SYNC_STAGES)) u_hw_sync (
        .clk(clk), .rst_n(rst_n), .async_i(hw_clr_pin_i), .sync_o(hw_clr_sync)
    );

    irq_change_det #(.WIDTH(WIDTH)) u_change (
        .clk(clk), .rst_n(rst_n), .status_i(status_i), .change_o(change_vec)
    );

    // Qualify events by mask and merge every clear source.
    always_comb begin
        set_vec = change_vec & mask_i;
        clr_vec = (clr_we_i ? clr_bits_i : '0) | {WIDTH{clr_all_i | hw_clr_sync}};
    end

    irq_flag_bank #(.WIDTH(WIDTH)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .flags_o(monitor_o)
    );

    // Interrupt condition: any flag raised.
    always_comb begin
        irq_level = |monitor_o;
    end

    irq_pin_drive u_pin (
        .clk(clk), .rst_n(rst_n), .mode_we_i(mode_we_i), .mode_i(mode_i),
        .irq_i(irq_level), .pin_o(irq_pin_o), .pin_oe_o(irq_pin_oe_o)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        $rose(rst_n) |-> (monitor_o == '0 && irq_pin_o && irq_pin_oe_o));  // R1
    AST_MASK_GATES_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((monitor_o & ~$past(monitor_o)) & ~$past(mask_i)) == '0));  // R3
    AST_HW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        hw_clr_sync |=> ((monitor_o & ~$past(set_vec)) == '0));  // R7
    AST_ASSERTED_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (monitor_o != '0) |-> irq_pin_oe_o);  // R9
endmodule

// File: tb/sim_irq_sticky_ctrl.sv
module sim_irq_sticky_ctrl;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] status = '0;
    logic [W-1:0] mask = '0;
    logic         clr_we = 1'b0;
    logic [W-1:0] clr_bits = '0;
    logic         clr_all = 1'b0;
    logic         hw_clr = 1'b0;
    logic         mode_we = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic [W-1:0] monitor;
    logic         pin, pin_oe;

    int checks = 0;
    int errors = 0;

    // Bench model state
    logic [W-1:0] exp_mon = '0;
    logic [W-1:0] prev_st = '0;
    logic         primed = 1'b0;
    logic         s1 = 1'b0, s2 = 1'b0;
    logic [1:0]   exp_mode = 2'b11;

    always #10 clk = ~clk;  // 50 MHz

    irq_sticky_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .status_i(status), .mask_i(mask),
        .clr_we_i(clr_we), .clr_bits_i(clr_bits), .clr_all_i(clr_all),
        .hw_clr_pin_i(hw_clr), .mode_we_i(mode_we), .mode_i(mode),
        .monitor_o(monitor), .irq_pin_o(pin), .irq_pin_oe_o(pin_oe)
    );

    function automatic logic [1:0] pin_exp(input logic [1:0] m, input logic a);
        case (m)
            2'b00:   return {a, 1'b0};
            2'b01:   return {a, 1'b1};
            2'b10:   return {1'b1, a};
            default: return {1'b1, ~a};
        endcase
    endfunction

    task automatic check_out(input string tag);
        logic [1:0] pe;
        pe = pin_exp(exp_mode, |exp_mon);
        checks++;
        if (monitor !== exp_mon) begin
            errors++;
            $display("FAIL %s monitor actual %h expected %h", tag, monitor, exp_mon);
        end
        checks++;
        if ({pin_oe, pin} !== pe) begin
            errors++;
            $display("FAIL R9 R10 %s pin {oe,data} actual %b%b expected %b", tag, pin_oe, pin, pe);
        end
    endtask

    // One clock: update the model from current inputs, clock, drop strobes, compare.
    task automatic cyc(input string tag);
        logic [W-1:0] ev, clr;
        ev  = primed ? (status ^ prev_st) : '0;
        clr = (clr_we ? clr_bits : '0) | ((clr_all || s2) ? '1 : '0);
        exp_mon = (exp_mon & ~clr) | (ev & mask);
        prev_st = status;
        primed  = 1'b1;
        s2 = s1;
        s1 = hw_clr;
        if (mode_we) exp_mode = mode;
        @(posedge clk);
        @(negedge clk);
        clr_we = 1'b0; clr_all = 1'b0; mode_we = 1'b0;
        check_out(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_out("R1");
        rst_n = 1'b1;
        mask = '1;
        status = 16'hA5A5;
        cyc("R1 R2 first cycle no event");
        check_out("R1");

        // Per-bit sweep, both directions, mask open and shut
        for (int i = 0; i < W; i++) begin
            for (int m = 0; m < 2; m++) begin
                mask = m[0] ? (16'h1 << i) : ~(16'h1 << i);
                status[i] = ~status[i];
                cyc(m[0] ? "R2 toggle unmasked" : "R3 toggle masked");
                status[i] = ~status[i];
                cyc(m[0] ? "R2 toggle back" : "R3 toggle back");
                mask = '0;
                cyc("R4 mask removed flag stays");
                clr_we = 1'b1; clr_bits = 16'h1 << i;
                cyc("R5 per-bit clear");
            end
        end

        // Pre-existing level then mask opened
        mask = '0; status = 16'h00F0; cyc("R3 hidden change");
        mask = '1; cyc("R3 mask over old level"); cyc("R3 still quiet");

        // Several flags, partial clear, pattern without strobe
        status = 16'h0F0F; cyc("R2 multi set");
        clr_bits = 16'h0300; clr_we = 1'b0; cyc("R5 pattern without strobe");
        clr_we = 1'b1; clr_bits = 16'h0300; cyc("R5 partial clear");
        clr_all = 1'b1; cyc("R6 clear all");

        // Hardware clear with synchronizer delay
        status = 16'hFFFF; cyc("R2 set all");
        hw_clr = 1'b1; cyc("R7 hw sample"); cyc("R7 hw stage two");
        cyc("R7 hw cleared");
        hw_clr = 1'b0; cyc("R7 release"); cyc("R7 release done");

        // Collisions: set and clear on the same bit in one cycle
        status = 16'hFF00; cyc("R2 reset flags");
        clr_all = 1'b1; cyc("R6 clean");
        status[3] = ~status[3]; clr_we = 1'b1; clr_bits = 16'h0008; cyc("R8 set vs bit clear");
        status[5] = ~status[5]; clr_all = 1'b1; cyc("R8 set vs clear all");
        hw_clr = 1'b1; cyc("R8 hw prep"); cyc("R8 hw prep2");
        status[9] = ~status[9]; cyc("R8 set vs hw clear");
        hw_clr = 1'b0; cyc("R8 hw drop"); cyc("R8 hw drop2");

        // Every drive mode, asserted and idle
        for (int md = 0; md < 4; md++) begin
            mode = md[1:0]; mode_we = 1'b1; cyc("R11 mode load");
            mode = ~md[1:0]; cyc("R11 mode without strobe");
            clr_all = 1'b1; cyc("R10 idle");
            status[0] = ~status[0]; cyc("R10 asserted");
        end

        // Pseudo-random run
        lfsr = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            status = status ^ (lfsr & {lfsr[7:0], lfsr[15:8]});
            mask   = lfsr ^ 16'h5A3C;
            clr_we = (lfsr[2:0] == 3'd0);
            clr_bits = {lfsr[3:0], lfsr[15:4]};
            clr_all = (lfsr[6:2] == 5'd7);
            hw_clr  = (lfsr[11:7] == 5'd3) ? ~hw_clr : hw_clr;
            mode_we = (lfsr[9:5] == 5'd1);
            mode    = lfsr[1:0];
            cyc("R2 R5 R8 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule